// File: doc/BRIEF.md
# Register-Reference Accumulator Unit

This block carries out the register-reference class of instructions for a small accumulator machine. It holds a 16-bit accumulator and a 1-bit extension flag. It receives the low 12 bits of an already decoded instruction together with an execute strobe. Each bit of that field enables one operation of its own, so one instruction word can combine several operations. Some operations change the accumulator or the extension flag. Others test them and ask the program counter to step past the next instruction. One bit stops the machine.

The operations that change state run in a fixed order within one strobe:

1. Clear.
2. Complement.
3. Circulate through the 17-bit ring formed by the extension flag and the accumulator.
4. Increment.

The skip tests look at the state as it was before the strobe. A skip appears as a one-cycle pulse after the strobe. A halt is held until reset, and while it is held the block ignores any further strobe.

Top module: `rr_acc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the accumulator, the extension flag, `skip_o` and `halt_o` to 0.
- R2: On a strobe, field bit 11 clears the accumulator and field bit 10 clears the extension flag.
- R3: Field bit 9 inverts the accumulator and field bit 8 inverts the extension flag. Both act after the clears of R2, so a field of 0xF00 gives an accumulator of 0xFFFF and a flag of 1.
- R4: Field bit 7 circulates {flag, accumulator} right: accumulator bit 0 goes to the flag and the flag goes to accumulator bit 15. Field bit 6 circulates left: accumulator bit 15 goes to the flag and the flag goes to accumulator bit 0. The circulate acts after R3. When bits 7 and 6 are both set, only the right circulate happens.
- R5: Field bit 5 adds one to the accumulator, modulo 2^16, as the last step. It leaves the extension flag unchanged.
- R6: Field bits 4, 3, 2 and 1 select four tests: accumulator bit 15 is 0, accumulator bit 15 is 1, accumulator is zero, and flag is 0. Each test uses the values from before the strobe. If any selected test is true, `skip_o` is 1 for exactly the one cycle after the strobe edge.
- R7: Field bit 0 sets `halt_o` from the cycle after the strobe. The other bits of the same word still take effect.
- R8: While `halt_o` is 1, strobes are ignored: the accumulator and the flag keep their values and `skip_o` stays 0. Only reset clears `halt_o`.
- R9: In a cycle with no strobe, the accumulator and the flag hold their values and `skip_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_i | input | 1 | Execute strobe for the current field |
| field_i | input | 12 | Low 12 bits of the decoded instruction, one operation per bit |
| acc_o | output | 16 | Accumulator |
| ext_o | output | 1 | Extension flag |
| skip_o | output | 1 | One-cycle request for an extra program-counter step |
| halt_o | output | 1 | Sticky halt flag |

## Verification
On every cycle, the assertions check the following:
- `skip_o` only follows an accepted strobe.
- The halt flag never falls.
- A halted or idle unit keeps its accumulator and flag.
- An increment-only word leaves the flag alone.

The arithmetic and the ordering cannot be shown by those properties, and only the bench's scenarios show them:
- the exact 17-bit ring movement;
- the priority of right over left;
- the clear-then-invert-then-circulate-then-increment sequence;
- skip tests seeing the values from before the strobe.

// File: rtl/rr_acc_pkg.sv
package rr_acc_pkg;
   localparam int FIELD_W    = 12;
   localparam int TEST_W     = 4;
   // field bit positions: the decoder upstream depends on these
   localparam int B_ZAC      = 11;
   localparam int B_ZEXT     = 10;
   localparam int B_NAC      = 9;
   localparam int B_NEXT     = 8;
   localparam int B_ROR      = 7;
   localparam int B_ROL      = 6;
   localparam int B_BUMP     = 5;
   localparam int B_TST_POS  = 4;
   localparam int B_TST_NEG  = 3;
   localparam int B_TST_ZERO = 2;
   localparam int B_TST_EZ   = 1;
   localparam int B_STOP     = 0;

   typedef struct packed {
      logic zac;
      logic zext;
      logic nac;
      logic next_inv;
      logic ror;
      logic rol;
      logic bump;
      logic [TEST_W-1:0] tests; // pos, neg, zero, ext-zero
      logic stop;
   } op_sel_t;

   function automatic op_sel_t split_field(input logic [FIELD_W-1:0] f);
      op_sel_t o;
      o.zac      = f[B_ZAC];
      o.zext     = f[B_ZEXT];
      o.nac      = f[B_NAC];
      o.next_inv = f[B_NEXT];
      o.ror      = f[B_ROR];
      o.rol      = f[B_ROL];
      o.bump     = f[B_BUMP];
      o.tests    = {f[B_TST_POS], f[B_TST_NEG], f[B_TST_ZERO], f[B_TST_EZ]};
      o.stop     = f[B_STOP];
      return o;
   endfunction
endpackage

// File: rtl/rr_acc_bitops.sv
module rr_acc_bitops #(
   parameter int ACC_W = 16
) (
   input  logic [ACC_W-1:0] acc_i,
   input  logic             ext_i,
   input  logic             zac_i,
   input  logic             zext_i,
   input  logic             nac_i,
   input  logic             next_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             ext_o
);
   logic [ACC_W-1:0] acc_clr;
   logic             ext_clr;

   always_comb begin
      acc_clr = zac_i  ? '0   : acc_i;
      ext_clr = zext_i ? 1'b0 : ext_i;
      acc_o   = nac_i  ? ~acc_clr : acc_clr;
      ext_o   = next_i ? ~ext_clr : ext_clr;
   end
endmodule

// File: rtl/rr_acc_rotate.sv
module rr_acc_rotate #(
   parameter int ACC_W = 16
) (
   input  logic [ACC_W-1:0] acc_i,
   input  logic             ext_i,
   input  logic             ror_i,
   input  logic             rol_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             ext_o
);
   logic [ACC_W-1:0] right_v;
   logic [ACC_W-1:0] left_v;

   for (genvar i = 0; i < ACC_W; i++) begin : g_lane
      if (i == ACC_W-1) begin : g_top
         assign right_v[i] = ext_i;
      end else begin : g_mid_r
         assign right_v[i] = acc_i[i+1];
      end
      if (i == 0) begin : g_bot
         assign left_v[i] = ext_i;
      end else begin : g_mid_l
         assign left_v[i] = acc_i[i-1];
      end
   end

   always_comb begin
      if (ror_i) begin
         acc_o = right_v;
         ext_o = acc_i[0];
      end else if (rol_i) begin
         acc_o = left_v;
         ext_o = acc_i[ACC_W-1];
      end else begin
         acc_o = acc_i;
         ext_o = ext_i;
      end
   end
endmodule

// File: rtl/rr_acc_skipeval.sv
module rr_acc_skipeval #(
   parameter int ACC_W  = 16,
   parameter int TEST_W = 4
) (
   input  logic [ACC_W-1:0]  acc_i,
   input  logic              ext_i,
   input  logic [TEST_W-1:0] sel_i,
   output logic              hit_o
);
   logic [TEST_W-1:0] cond;

   always_comb begin
      cond[3] = ~acc_i[ACC_W-1];
      cond[2] =  acc_i[ACC_W-1];
      cond[1] = (acc_i == '0);
      cond[0] = ~ext_i;
      hit_o   = |(cond & sel_i);
   end
endmodule

// File: rtl/rr_acc_unit.sv
module rr_acc_unit #(
   parameter int ACC_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        exec_i,
   input  logic [rr_acc_pkg::FIELD_W-1:0] field_i,
   output logic [ACC_W-1:0]            acc_o,
   output logic                        ext_o,
   output logic                        skip_o,
   output logic                        halt_o
);
   import rr_acc_pkg::*;

   if (ACC_W < 2) begin : g_bad_width
      $error("rr_acc_unit: ACC_W must be at least 2");
   end
   if (TEST_W != 4) begin : g_bad_tests
      $error("rr_acc_unit: four skip tests expected");
   end

   op_sel_t          op;
   logic [ACC_W-1:0] acc_q, acc_s1, acc_s2, acc_nx;
   logic             ext_q, ext_s1, ext_s2;
   logic             skip_q, halt_q, hit, go;

   assign op = split_field(field_i);
   assign go = exec_i && !halt_q;

   rr_acc_bitops #(.ACC_W(ACC_W)) u_bitops (
      .acc_i (acc_q),  .ext_i (ext_q),
      .zac_i (op.zac), .zext_i(op.zext),
      .nac_i (op.nac), .next_i(op.next_inv),
      .acc_o (acc_s1), .ext_o (ext_s1)
   );

   rr_acc_rotate #(.ACC_W(ACC_W)) u_rotate (
      .acc_i (acc_s1), .ext_i (ext_s1),
      .ror_i (op.ror), .rol_i (op.rol),
      .acc_o (acc_s2), .ext_o (ext_s2)
   );

   rr_acc_skipeval #(.ACC_W(ACC_W), .TEST_W(TEST_W)) u_skip (
      .acc_i (acc_q), .ext_i (ext_q),
      .sel_i (op.tests), .hit_o(hit)
   );

   assign acc_nx = op.bump ? acc_s2 + ACC_W'(1) : acc_s2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         ext_q  <= 1'b0;
         skip_q <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         skip_q <= go && hit;
         if (go) begin
            acc_q <= acc_nx;
            ext_q <= ext_s2;
            if (op.stop) halt_q <= 1'b1;
         end
      end
   end

   assign acc_o  = acc_q;
   assign ext_o  = ext_q;
   assign skip_o = skip_q;
   assign halt_o = halt_q;

   // R6: a skip pulse only follows an accepted strobe
   a_r6_skip_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q |-> $past(go));
   // R7: stop bit raises halt on the next edge
   a_r7_stop_sets_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (go && field_i[B_STOP]) |=> halt_q);
   // R8: halt is sticky and freezes state
   a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> halt_q);
   a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> ($stable(acc_q) && $stable(ext_q) && !skip_q));
   // R9: idle cycles hold state
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> ($stable(acc_q) && $stable(ext_q) && !skip_q));
   // R5: an increment-only word leaves the flag alone
   a_r5_bump_keeps_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (go && field_i == 12'h020) |=> (ext_q == $past(ext_q)));
endmodule

// File: tb/rr_acc_unit_tb.sv
module rr_acc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [11:0] field_i = '0;
   logic [15:0] acc_o;
   logic        ext_o, skip_o, halt_o;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   rr_acc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .field_i(field_i),
      .acc_o(acc_o), .ext_o(ext_o), .skip_o(skip_o), .halt_o(halt_o)
   );

   // {field, expected acc, expected ext, expected skip}, applied in order
   localparam int NV = 21;
   localparam logic [29:0] VEC [NV] = '{
      {12'h020, 16'h0001, 1'b0, 1'b0}, // R5 increment
      {12'h004, 16'h0001, 1'b0, 1'b0}, // R6 zero test false
      {12'h010, 16'h0001, 1'b0, 1'b1}, // R6 positive test
      {12'h200, 16'hFFFE, 1'b0, 1'b0}, // R3 invert acc
      {12'h008, 16'hFFFE, 1'b0, 1'b1}, // R6 negative test
      {12'h020, 16'hFFFF, 1'b0, 1'b0}, // R5
      {12'h020, 16'h0000, 1'b0, 1'b0}, // R5 wrap
      {12'h100, 16'h0000, 1'b1, 1'b0}, // R3 invert ext
      {12'h020, 16'h0001, 1'b1, 1'b0}, // R5 ext unchanged
      {12'h080, 16'h8000, 1'b1, 1'b0}, // R4 right
      {12'h040, 16'h0001, 1'b1, 1'b0}, // R4 left
      {12'h040, 16'h0003, 1'b0, 1'b0}, // R4 left
      {12'h002, 16'h0003, 1'b0, 1'b1}, // R6 ext-zero test
      {12'h0C0, 16'h0001, 1'b1, 1'b0}, // R4 both -> right only
      {12'h800, 16'h0000, 1'b1, 1'b0}, // R2 clear acc
      {12'h400, 16'h0000, 1'b0, 1'b0}, // R2 clear ext
      {12'hF00, 16'hFFFF, 1'b1, 1'b0}, // R3 after clears
      {12'h024, 16'h0000, 1'b1, 1'b0}, // R6 old value nonzero
      {12'h024, 16'h0001, 1'b1, 1'b1}, // R6 old value zero
      {12'h01A, 16'h0001, 1'b1, 1'b1}, // R6 OR of tests
      {12'hA20, 16'h0000, 1'b1, 1'b0}  // R5 last in order
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [11:0] f);
      @(negedge clk); exec_i = 1'b1; field_i = f;
      @(negedge clk); exec_i = 1'b0; field_i = '0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 acc", 32'(acc_o), 32'h0);
      chk("R1 ext", 32'(ext_o), 32'h0);
      chk("R1 skip", 32'(skip_o), 32'h0);
      chk("R1 halt", 32'(halt_o), 32'h0);

      for (int i = 0; i < NV; i++) begin
         strobe(VEC[i][29:18]);
         chk($sformatf("R2-5 vec%0d acc", i), 32'(acc_o), 32'(VEC[i][17:2]));
         chk($sformatf("R4 vec%0d ext", i), 32'(ext_o), 32'(VEC[i][1]));
         chk($sformatf("R6 vec%0d skip", i), 32'(skip_o), 32'(VEC[i][0]));
      end

      // R6: pulse lasts one cycle
      strobe(12'h010);
      chk("R6 pulse", 32'(skip_o), 32'h1);
      @(negedge clk);
      chk("R6 pulse ends", 32'(skip_o), 32'h0);

      // R9: no strobe, with a field present
      field_i = 12'hFFF;
      repeat (3) @(negedge clk);
      chk("R9 acc hold", 32'(acc_o), 32'h0);
      chk("R9 ext hold", 32'(ext_o), 32'h1);
      chk("R9 no skip", 32'(skip_o), 32'h0);
      field_i = '0;

      // R7: stop with increment in the same word
      strobe(12'h021);
      chk("R7 halt", 32'(halt_o), 32'h1);
      chk("R7 bump applied", 32'(acc_o), 32'h0001);

      // R8: strobes ignored while halted
      strobe(12'h830);
      chk("R8 acc frozen", 32'(acc_o), 32'h0001);
      chk("R8 ext frozen", 32'(ext_o), 32'h1);
      chk("R8 no skip", 32'(skip_o), 32'h0);
      chk("R8 halt sticky", 32'(halt_o), 32'h1);

      // R1: reset releases halt and clears state
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 halt cleared", 32'(halt_o), 32'h0);
      chk("R1 acc cleared", 32'(acc_o), 32'h0);
      chk("R1 ext cleared", 32'(ext_o), 32'h0);
      strobe(12'h020);
      chk("R1 runs after reset", 32'(acc_o), 32'h0001);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule